// File: doc/BRIEF.md
# Two-Arm Coincidence Trigger with Per-Source Prescaling

This block forms the trigger for a detector with a left and a right arm. Each arm has a calorimeter of eight channels and a scintillator plane read out as four pairs of channels. Every clock cycle the block takes the digitized amplitudes of all channels. For each arm it raises a calorimeter flag when the arm's eight-channel sum is above a threshold. It raises a scintillator flag when at least one of the arm's four pair sums is above a second threshold.

From the four flags it builds seven trigger sources. Some are single arms, some are coincidences, and one is a coincidence against a scintillator term delayed by a programmable number of cycles. Each source has its own enable and its own prescaler. The final trigger is the OR of the prescaled sources. Alongside, every source has a counter of its occurrences. A helicity strobe copies the counters into holding registers and restarts them, so no occurrence is lost between two readouts.

The thresholds, prescale factors, enables and delay are plain configuration inputs. They are expected to be held steady by a register block outside.

Top module: `coinc_trigger`

## Requirements
- R1: For each arm, the calorimeter flag is set when the unsigned sum of its eight channel amplitudes is strictly greater than that arm's calorimeter threshold. A sum equal to the threshold does not set it. The left arm is index 0 of every two-arm vector and the right arm is index 1.
- R2: For each arm, the scintillator flag is set when the sum of at least one of its four channel pairs is strictly greater than that arm's scintillator threshold. Channel j of pair p of arm a sits at amplitude slot (a*4+p)*2+j.
- R3: The source bit positions are: 0 left calorimeter, 1 right calorimeter, 2 both calorimeters, 3 left calorimeter and left scintillator, 4 right calorimeter and right scintillator, 5 all four flags, 6 both calorimeters and the delayed term (both scintillators).
- R4: A source occurrence is a rising edge of its term. Inputs presented in one cycle produce the resulting one-cycle pulse on `src_pass_o` two clock edges later. A term held high for many cycles counts once.
- R5: With prescale factor N, a source passes its Nth, 2Nth, ... occurrence. A factor of 0 or 1 passes every occurrence.
- R6: A source whose enable bit is low never passes, and its prescaler count is frozen. Occurrences resume counting toward the factor from the frozen value once the source is enabled again.
- R7: The delayed term is the both-scintillators condition from `delay_i` cycles earlier. A value of 0 means no delay, and values above 32 act as 32.
- R8: `trig_o` is high exactly in the cycles in which at least one bit of `src_pass_o` is high.
- R9: Each source counts all occurrences of its term, whatever its enable or prescaler. On a cycle with `hel_strobe_i` high, the count is copied to that source's field of `cnt_hold_o`, and this copy includes an occurrence found in that same cycle. The count then restarts from zero. Source s uses bits s*24 and up.
- R10: While reset is asserted, and in the first cycle after it, `trig_o`, `src_pass_o` and `cnt_hold_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_amp_i | input | 192 | Calorimeter amplitudes, 12 bits each, left arm channels 0..7 then right arm |
| scin_amp_i | input | 192 | Scintillator amplitudes, 12 bits each, slot (arm*4+pair)*2+channel |
| cal_thr_i | input | 30 | Calorimeter thresholds, 15 bits each, left in low half |
| scin_thr_i | input | 26 | Scintillator pair thresholds, 13 bits each, left in low half |
| presc_i | input | 70 | Prescale factor, 10 bits per source, source s at bit s*10 |
| src_en_i | input | 7 | Enable bit per source |
| delay_i | input | 6 | Delay of the scintillator term in cycles |
| hel_strobe_i | input | 1 | Helicity readout strobe |
| trig_o | output | 1 | Final trigger pulse |
| src_pass_o | output | 7 | Prescaled pulse per source |
| cnt_hold_o | output | 168 | Held occurrence counts, 24 bits per source |

## Verification
A wrong prescaler count shows up at the ports on the next occurrence of that source. The pulse then arrives one occurrence too early or too late against the factor, two cycles after the inputs that caused it. A flag or edge register that is stuck appears in the same two-cycle window, as a missing pulse or as a repeated pulse for a held condition. A damaged delay tap lets the delayed coincidence fire one cycle off, which a pulse pair placed exactly `delay_i` cycles apart exposes. A lost or double count stays hidden until the next helicity strobe, when the held value differs from the number of occurrences seen since the previous strobe.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;

    localparam int NSRC = 7;

    // Source bit positions (R3)
    typedef enum logic [2:0] {
        SRC_CAL_L    = 3'd0,
        SRC_CAL_R    = 3'd1,
        SRC_CAL_LR   = 3'd2,
        SRC_ARM_L    = 3'd3,
        SRC_ARM_R    = 3'd4,
        SRC_ALL      = 3'd5,
        SRC_DELAYED  = 3'd6
    } src_e;

endpackage

// File: rtl/ctrig_arm_flags.sv
// One detector arm: calorimeter sum compare and scintillator pair-sum compare,
// flags registered (R1, R2).
module ctrig_arm_flags #(
    parameter  int AMP_W  = 12,
    parameter  int NCAL   = 8,
    parameter  int NPAIR  = 4,
    localparam int CSUM_W = AMP_W + $clog2(NCAL),
    localparam int PSUM_W = AMP_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCAL*AMP_W-1:0]       cal_amp_i,
    input  logic [2*NPAIR*AMP_W-1:0]    scin_amp_i,
    input  logic [CSUM_W-1:0]           cal_thr_i,
    input  logic [PSUM_W-1:0]           scin_thr_i,
    output logic                        cal_flag_o,
    output logic                        scin_flag_o
);

    typedef struct packed {
        logic cal;
        logic scin;
    } flag_t;

    flag_t st_d, st_q;

    logic [CSUM_W-1:0] cal_sum;
    logic [NPAIR-1:0]  pair_hit;

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            logic [PSUM_W-1:0] pair_sum;
            assign pair_sum    = PSUM_W'(scin_amp_i[(2*p)*AMP_W +: AMP_W])
                               + PSUM_W'(scin_amp_i[(2*p+1)*AMP_W +: AMP_W]);
            assign pair_hit[p] = pair_sum > scin_thr_i;
        end
    endgenerate

    always_comb begin
        cal_sum = '0;
        for (int c = 0; c < NCAL; c++) begin
            cal_sum = cal_sum + CSUM_W'(cal_amp_i[c*AMP_W +: AMP_W]);
        end
        st_d      = st_q;
        st_d.cal  = cal_sum > cal_thr_i;
        st_d.scin = |pair_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cal_flag_o  = st_q.cal;
    assign scin_flag_o = st_q.scin;

endmodule

// File: rtl/ctrig_delay_line.sv
// Programmable delay of a single bit: tap 0 is the live bit, tap k is k cycles old (R7).
module ctrig_delay_line #(
    parameter  int DEPTH = 32,
    localparam int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    typedef struct packed {
        logic [DEPTH-1:0] sr;
    } dl_t;

    dl_t st_d, st_q;

    logic [SEL_W-1:0] sel_eff;
    logic [DEPTH:0]   taps;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[DEPTH-2:0], bit_i};
        sel_eff = (sel_i > SEL_W'(DEPTH)) ? SEL_W'(DEPTH) : sel_i;
        taps    = {st_q.sr, bit_i};
        bit_o   = taps[sel_eff];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ctrig_prescaler.sv
// Rising-edge detector and divide-by-N pass gate for one source (R4, R5, R6).
module ctrig_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic             en_i,
    input  logic [PRE_W-1:0] factor_i,
    output logic             edge_o,
    output logic             fire_o,
    output logic             pass_o
);

    typedef struct packed {
        logic             prev;
        logic [PRE_W-1:0] cnt;
        logic             pass;
    } ps_t;

    ps_t st_d, st_q;

    logic [PRE_W-1:0] limit;
    logic [PRE_W:0]   cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.prev = raw_i;
        st_d.pass = 1'b0;
        edge_o    = raw_i & ~st_q.prev;
        limit     = (factor_i == '0) ? PRE_W'(1) : factor_i;
        cnt_inc   = {1'b0, st_q.cnt} + (PRE_W+1)'(1);
        if (edge_o && en_i) begin
            if (cnt_inc >= {1'b0, limit}) begin
                st_d.cnt  = '0;
                st_d.pass = 1'b1;
            end else begin
                st_d.cnt  = cnt_inc[PRE_W-1:0];
            end
        end
        fire_o = st_d.pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pass_o = st_q.pass;

endmodule

// File: rtl/ctrig_term_counter.sv
// Occurrence counter with strobe-driven hold register; live count saturates (R9).
module ctrig_term_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             strobe_i,
    output logic [CNT_W-1:0] hold_o
);

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] hold;
    } tc_t;

    tc_t st_d, st_q;

    logic [CNT_W-1:0] upd;

    always_comb begin
        st_d = st_q;
        upd  = (st_q.live == '1) ? st_q.live : st_q.live + CNT_W'(edge_i);
        if (strobe_i) begin
            st_d.hold = upd;
            st_d.live = '0;
        end else begin
            st_d.live = upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_trig_pkg::*;
#(
    parameter  int AMP_W   = 12,
    parameter  int NCAL    = 8,
    parameter  int NPAIR   = 4,
    parameter  int PRE_W   = 10,
    parameter  int DLY_MAX = 32,
    parameter  int CNT_W   = 24,
    localparam int CSUM_W  = AMP_W + $clog2(NCAL),
    localparam int PSUM_W  = AMP_W + 1,
    localparam int DLY_W   = $clog2(DLY_MAX + 1),
    localparam int ARM_CAL = NCAL * AMP_W,
    localparam int ARM_SC  = 2 * NPAIR * AMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*ARM_CAL-1:0]   cal_amp_i,
    input  logic [2*ARM_SC-1:0]    scin_amp_i,
    input  logic [2*CSUM_W-1:0]    cal_thr_i,
    input  logic [2*PSUM_W-1:0]    scin_thr_i,
    input  logic [NSRC*PRE_W-1:0]  presc_i,
    input  logic [NSRC-1:0]        src_en_i,
    input  logic [DLY_W-1:0]       delay_i,
    input  logic                   hel_strobe_i,
    output logic                   trig_o,
    output logic [NSRC-1:0]        src_pass_o,
    output logic [NSRC*CNT_W-1:0]  cnt_hold_o
);

    typedef struct packed {
        logic trig;
    } top_t;

    top_t st_d, st_q;

    logic [1:0]      cal_flag;
    logic [1:0]      scin_flag;
    logic            scin_both_dly;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] edge_v;
    logic [NSRC-1:0] fire_v;

    // Per-arm flag formation (R1, R2)
    generate
        for (genvar a = 0; a < 2; a++) begin : g_arm
            ctrig_arm_flags #(
                .AMP_W (AMP_W),
                .NCAL  (NCAL),
                .NPAIR (NPAIR)
            ) u_arm (
                .clk         (clk),
                .rst_n       (rst_n),
                .cal_amp_i   (cal_amp_i[a*ARM_CAL +: ARM_CAL]),
                .scin_amp_i  (scin_amp_i[a*ARM_SC +: ARM_SC]),
                .cal_thr_i   (cal_thr_i[a*CSUM_W +: CSUM_W]),
                .scin_thr_i  (scin_thr_i[a*PSUM_W +: PSUM_W]),
                .cal_flag_o  (cal_flag[a]),
                .scin_flag_o (scin_flag[a])
            );
        end
    endgenerate

    // Delayed both-scintillator term (R7)
    ctrig_delay_line #(
        .DEPTH (DLY_MAX)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (scin_flag[0] & scin_flag[1]),
        .sel_i (delay_i),
        .bit_o (scin_both_dly)
    );

    // Trigger source terms (R3)
    always_comb begin
        raw              = '0;
        raw[SRC_CAL_L]   = cal_flag[0];
        raw[SRC_CAL_R]   = cal_flag[1];
        raw[SRC_CAL_LR]  = cal_flag[0] & cal_flag[1];
        raw[SRC_ARM_L]   = cal_flag[0] & scin_flag[0];
        raw[SRC_ARM_R]   = cal_flag[1] & scin_flag[1];
        raw[SRC_ALL]     = &{cal_flag, scin_flag};
        raw[SRC_DELAYED] = cal_flag[0] & cal_flag[1] & scin_both_dly;
    end

    // Per-source prescaler and occurrence counter (R5, R6, R9)
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            ctrig_prescaler #(
                .PRE_W (PRE_W)
            ) u_ps (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_i    (raw[s]),
                .en_i     (src_en_i[s]),
                .factor_i (presc_i[s*PRE_W +: PRE_W]),
                .edge_o   (edge_v[s]),
                .fire_o   (fire_v[s]),
                .pass_o   (src_pass_o[s])
            );

            ctrig_term_counter #(
                .CNT_W (CNT_W)
            ) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .edge_i   (edge_v[s]),
                .strobe_i (hel_strobe_i),
                .hold_o   (cnt_hold_o[s*CNT_W +: CNT_W])
            );
        end
    endgenerate

    // Final trigger register (R8)
    always_comb begin
        st_d      = st_q;
        st_d.trig = |fire_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o = st_q.trig;

endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
    parameter int NSRC  = 7,
    parameter int CNT_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NSRC-1:0]       src_en_i,
    input logic                  hel_strobe_i,
    input logic                  trig_o,
    input logic [NSRC-1:0]       src_pass_o,
    input logic [NSRC*CNT_W-1:0] cnt_hold_o
);

    // R4: an occurrence is an edge, so no source passes on two cycles in a row
    assert_no_back_to_back_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (src_pass_o & $past(src_pass_o)) == '0
    );

    // R8: final trigger matches the per-source pulses
    assert_trig_matches_sources_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        trig_o == (|src_pass_o)
    );

    // R6: a source disabled at the deciding edge does not pass
    assert_disabled_silent_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (src_pass_o & ~$past(src_en_i)) == '0
    );

    // R9: held counts change only after a strobe
    assert_hold_only_on_strobe_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$past(hel_strobe_i) |-> $stable(cnt_hold_o)
    );

    // R10: outputs are cleared by reset and stay clear one cycle after it
    assert_reset_quiet_R10: assert property (
        @(posedge clk)
        !rst_n |=> (src_pass_o == '0 && cnt_hold_o == '0 && !trig_o)
    );

endmodule

bind coinc_trigger coinc_trigger_chk #(
    .NSRC  (coinc_trig_pkg::NSRC),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_en_i     (src_en_i),
    .hel_strobe_i (hel_strobe_i),
    .trig_o       (trig_o),
    .src_pass_o   (src_pass_o),
    .cnt_hold_o   (cnt_hold_o)
);

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;

    localparam int AMP_W   = 12;
    localparam int NCAL    = 8;
    localparam int NPAIR   = 4;
    localparam int PRE_W   = 10;
    localparam int DLY_MAX = 32;
    localparam int CNT_W   = 24;
    localparam int NSRC    = 7;
    localparam int CSUM_W  = 15;
    localparam int PSUM_W  = 13;
    localparam int DLY_W   = 6;
    localparam int HW      = NSRC * CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2*NCAL*AMP_W-1:0]    cal_amp;
    logic [4*NPAIR*AMP_W-1:0]   scin_amp;
    logic [2*CSUM_W-1:0]        cal_thr;
    logic [2*PSUM_W-1:0]        scin_thr;
    logic [NSRC*PRE_W-1:0]      presc;
    logic [NSRC-1:0]            src_en;
    logic [DLY_W-1:0]           delay;
    logic                       hel_strobe;
    logic                       trig;
    logic [NSRC-1:0]            src_pass;
    logic [HW-1:0]              cnt_hold;

    coinc_trigger uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_amp_i    (cal_amp),
        .scin_amp_i   (scin_amp),
        .cal_thr_i    (cal_thr),
        .scin_thr_i   (scin_thr),
        .presc_i      (presc),
        .src_en_i     (src_en),
        .delay_i      (delay),
        .hel_strobe_i (hel_strobe),
        .trig_o       (trig),
        .src_pass_o   (src_pass),
        .cnt_hold_o   (cnt_hold)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(string tag, string what, logic [HW-1:0] act, logic [HW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model state, written from the requirements
    int  m_cal[2][NCAL];
    int  m_sc[2][NPAIR][2];
    int  m_cthr[2];
    int  m_sthr[2];
    int  m_presc[NSRC];
    bit  m_en[NSRC];
    int  m_dly;
    bit  m_hist[8192];
    int  m_step = 0;
    bit  m_prev[NSRC];
    int  m_pcnt[NSRC];
    int  m_live[NSRC];

    // Scoreboard queues
    int               pdue_q[$];
    logic [NSRC-1:0]  pexp_q[$];
    string            ptag_q[$];
    int               hdue_q[$];
    logic [HW-1:0]    hexp_q[$];
    string            htag_q[$];

    task automatic zero_amps();
        for (int a = 0; a < 2; a++) begin
            for (int c = 0; c < NCAL; c++) m_cal[a][c] = 0;
            for (int p = 0; p < NPAIR; p++) begin
                m_sc[a][p][0] = 0;
                m_sc[a][p][1] = 0;
            end
        end
    endtask

    task automatic drive_ports(bit strobe);
        for (int a = 0; a < 2; a++) begin
            for (int c = 0; c < NCAL; c++)
                cal_amp[(a*NCAL+c)*AMP_W +: AMP_W] = AMP_W'(m_cal[a][c]);
            for (int p = 0; p < NPAIR; p++)
                for (int j = 0; j < 2; j++)
                    scin_amp[((a*NPAIR+p)*2+j)*AMP_W +: AMP_W] = AMP_W'(m_sc[a][p][j]);
            cal_thr[a*CSUM_W +: CSUM_W]  = CSUM_W'(m_cthr[a]);
            scin_thr[a*PSUM_W +: PSUM_W] = PSUM_W'(m_sthr[a]);
        end
        for (int s = 0; s < NSRC; s++) begin
            presc[s*PRE_W +: PRE_W] = PRE_W'(m_presc[s]);
            src_en[s] = m_en[s];
        end
        delay      = DLY_W'(m_dly);
        hel_strobe = strobe;
    endtask

    // Driver: one cycle of stimulus, pushes expected results
    task automatic step(string tag, bit strobe);
        bit cl, cr, sl, sr, scb, dly_bit;
        int sum, deff, nfac;
        bit [NSRC-1:0] rawv;
        logic [NSRC-1:0] expv;
        logic [HW-1:0] hexp;
        bit [1:0] calf, scf;
        @(negedge clk);
        drive_ports(strobe);
        if (strobe) begin
            hexp = '0;
            for (int s = 0; s < NSRC; s++) begin
                hexp[s*CNT_W +: CNT_W] = CNT_W'(m_live[s]);
                m_live[s] = 0;
            end
            hdue_q.push_back(cyc + 1);
            hexp_q.push_back(hexp);
            htag_q.push_back({tag, "/R9"});
        end
        for (int a = 0; a < 2; a++) begin
            sum = 0;
            for (int c = 0; c < NCAL; c++) sum += m_cal[a][c];
            calf[a] = sum > m_cthr[a];
            scf[a] = 1'b0;
            for (int p = 0; p < NPAIR; p++)
                if (m_sc[a][p][0] + m_sc[a][p][1] > m_sthr[a]) scf[a] = 1'b1;
        end
        cl = calf[0]; cr = calf[1]; sl = scf[0]; sr = scf[1];
        scb = sl & sr;
        m_hist[m_step] = scb;
        deff = (m_dly > DLY_MAX) ? DLY_MAX : m_dly;
        if (deff == 0)            dly_bit = scb;
        else if (m_step >= deff)  dly_bit = m_hist[m_step - deff];
        else                      dly_bit = 1'b0;
        rawv[0] = cl;
        rawv[1] = cr;
        rawv[2] = cl & cr;
        rawv[3] = cl & sl;
        rawv[4] = cr & sr;
        rawv[5] = cl & cr & sl & sr;
        rawv[6] = cl & cr & dly_bit;
        expv = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (rawv[s] && !m_prev[s]) begin
                m_live[s]++;
                if (m_en[s]) begin
                    nfac = (m_presc[s] == 0) ? 1 : m_presc[s];
                    m_pcnt[s]++;
                    if (m_pcnt[s] >= nfac) begin
                        m_pcnt[s] = 0;
                        expv[s] = 1'b1;
                    end
                end
            end
            m_prev[s] = rawv[s];
        end
        pdue_q.push_back(cyc + 2);
        pexp_q.push_back(expv);
        ptag_q.push_back(tag);
        m_step++;
    endtask

    // Monitor: pops expected items when they fall due
    always @(negedge clk) begin
        if (pdue_q.size() > 0 && pdue_q[0] == cyc) begin
            logic [NSRC-1:0] e;
            string t;
            e = pexp_q.pop_front();
            t = ptag_q.pop_front();
            void'(pdue_q.pop_front());
            chk(t, "src_pass_o", HW'(src_pass), HW'(e));
            chk({t, "/R8"}, "trig_o", HW'(trig), HW'(|e));
        end
        if (hdue_q.size() > 0 && hdue_q[0] == cyc) begin
            logic [HW-1:0] h;
            string t;
            h = hexp_q.pop_front();
            t = htag_q.pop_front();
            void'(hdue_q.pop_front());
            chk(t, "cnt_hold_o", cnt_hold, h);
        end
    end

    task automatic idle(int n, string tag);
        zero_amps();
        for (int i = 0; i < n; i++) step(tag, 1'b0);
    endtask

    task automatic set_cal(int a, int total);
        for (int c = 0; c < NCAL; c++)
            m_cal[a][c] = total / NCAL + ((c < total % NCAL) ? 1 : 0);
    endtask

    task automatic pulse(string tag, int gap);
        step(tag, 1'b0);
        idle(gap, tag);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        zero_amps();
        for (int a = 0; a < 2; a++) begin
            m_cthr[a] = 100;
            m_sthr[a] = 50;
        end
        for (int s = 0; s < NSRC; s++) begin
            m_presc[s] = 1;
            m_en[s] = 1'b1;
            m_prev[s] = 1'b0;
            m_pcnt[s] = 0;
            m_live[s] = 0;
        end
        m_dly = 0;
        drive_ports(1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "trig_o in reset", HW'(trig), '0);
        chk("R10", "src_pass_o in reset", HW'(src_pass), '0);
        chk("R10", "cnt_hold_o in reset", cnt_hold, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "src_pass_o after reset", HW'(src_pass), '0);
        chk("R10", "cnt_hold_o after reset", cnt_hold, '0);

        // R1: calorimeter sum threshold, strict compare, both arms
        set_cal(0, 100); pulse("R1 left sum equal", 2);
        set_cal(0, 101); pulse("R1 left sum above", 2);
        set_cal(1, 100); pulse("R1 right sum equal", 2);
        set_cal(1, 101); pulse("R1 right sum above", 2);
        set_cal(0, 300); set_cal(1, 300); pulse("R3 both calorimeters", 2);

        // R2: any pair over threshold, strict compare
        set_cal(0, 200); m_sc[0][2][0] = 25; m_sc[0][2][1] = 25; pulse("R2 left pair equal", 2);
        set_cal(0, 200); m_sc[0][2][0] = 25; m_sc[0][2][1] = 26; pulse("R2 left pair above", 2);
        set_cal(1, 200); m_sc[1][3][0] = 40; m_sc[1][3][1] = 11; pulse("R2 right pair above", 2);
        set_cal(1, 200); m_sc[1][0][0] = 30; m_sc[1][1][1] = 30; pulse("R2 split channels", 2);
        set_cal(0, 200); set_cal(1, 200);
        m_sc[0][0][0] = 60; m_sc[1][1][0] = 60; pulse("R3 all four flags", 2);

        // R4: held condition counts once
        set_cal(0, 500);
        for (int i = 0; i < 6; i++) step("R4 held", 1'b0);
        idle(2, "R4 release");

        // R5: prescale by 3, then factor 0
        idle(1, "R5 cfg"); m_presc[0] = 3;
        for (int i = 0; i < 7; i++) begin set_cal(0, 150); pulse("R5 factor 3", 1); end
        idle(1, "R5 cfg"); m_presc[0] = 0;
        for (int i = 0; i < 3; i++) begin set_cal(0, 150); pulse("R5 factor 0", 1); end
        idle(1, "R5 cfg"); m_presc[0] = 1;

        // R6: disable freezes the prescaler
        idle(1, "R6 cfg"); m_presc[1] = 2;
        set_cal(1, 150); pulse("R6 enabled first", 1);
        idle(1, "R6 cfg"); m_en[1] = 1'b0;
        for (int i = 0; i < 3; i++) begin set_cal(1, 150); pulse("R6 disabled", 1); end
        idle(1, "R6 cfg"); m_en[1] = 1'b1;
        set_cal(1, 150); pulse("R6 re-enabled", 1);
        set_cal(1, 150); pulse("R6 re-enabled", 1);
        idle(1, "R6 cfg"); m_presc[1] = 1;

        // R7: delayed coincidence
        idle(1, "R7 cfg"); m_dly = 5;
        m_sc[0][0][0] = 60; m_sc[1][0][0] = 60; step("R7 scint", 1'b0);
        idle(4, "R7 wait");
        set_cal(0, 200); set_cal(1, 200); pulse("R7 delay 5 hit", 8);
        m_sc[0][0][0] = 60; m_sc[1][0][0] = 60; step("R7 scint", 1'b0);
        idle(3, "R7 wait");
        set_cal(0, 200); set_cal(1, 200); pulse("R7 delay 5 early", 8);
        idle(1, "R7 cfg"); m_dly = 0;
        set_cal(0, 200); set_cal(1, 200);
        m_sc[0][0][0] = 60; m_sc[1][0][0] = 60; pulse("R7 no delay", 3);
        idle(1, "R7 cfg"); m_dly = 40;
        m_sc[0][1][1] = 60; m_sc[1][1][1] = 60; step("R7 scint", 1'b0);
        idle(31, "R7 wait");
        set_cal(0, 200); set_cal(1, 200); pulse("R7 clamp 32", 3);

        // R9: counter windows, strobe next to occurrences
        idle(1, "R9 clear"); step("R9 clear", 1'b1);
        for (int i = 0; i < 4; i++) begin set_cal(0, 150); pulse("R9 count", 1); end
        step("R9 strobe", 1'b1);
        set_cal(0, 150); set_cal(1, 150); step("R9 strobe with input", 1'b1);
        step("R9 strobe after input", 1'b1);
        set_cal(1, 150); step("R9 input", 1'b0);
        idle(1, "R9"); step("R9 strobe", 1'b1);

        // Mixed traffic
        idle(1, "mix cfg");
        m_cthr[0] = 200; m_cthr[1] = 210; m_sthr[0] = 45; m_sthr[1] = 50;
        m_presc[0] = 2; m_presc[1] = 3; m_presc[2] = 1; m_presc[3] = 2;
        m_presc[4] = 1; m_presc[5] = 4; m_presc[6] = 1;
        m_en[4] = 1'b0; m_dly = 3;
        for (int i = 0; i < 400; i++) begin
            for (int a = 0; a < 2; a++) begin
                for (int c = 0; c < NCAL; c++) m_cal[a][c] = $urandom_range(0, 55);
                for (int p = 0; p < NPAIR; p++) begin
                    m_sc[a][p][0] = $urandom_range(0, 30);
                    m_sc[a][p][1] = $urandom_range(0, 30);
                end
            end
            step("R3 R5 mixed", (i % 37) == 36);
        end
        idle(1, "mix end");
        step("R9 final strobe", 1'b1);
        idle(4, "drain");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule